// File: doc/BRIEF.md
# Variable-Width FIFO SPI Master

This block is a register-mapped SPI master. Software sets the clock divider, the clock polarity and phase, and the bit order through two control registers. It then queues transmit entries. Each entry carries its own shift length of 8, 16 or 24 bits. The length comes from the top byte of the written word, or from a fixed length field when the variable-width mode is off. One data address ends an entry with the chip select still asserted. A second data address ends the entry with the chip select released. This lets a frame of any length be built from several entries.

Every completed entry produces one receive entry. Software reads it back left-aligned, or inspects it without removing it. The block drives a single active-low chip select and adds one idle serial clock period after every eighth bit. It raises an interrupt line when the enabled conditions hold, either the transmit queue running empty or the engine going idle.

Top module: `vwspi_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0 and irq is 0, and the status register reads 0x00000280 (TX empty bit 9 and RX empty bit 7 set, all levels 0).
- R2: The control register 0 divider field in bits 31:20 sets each half of a serial clock period to divider+1 system clocks, so sclk spends divider+1 cycles at its active level for every bit.
- R3: With control register 0 bit 14 set, bits 31:24 of a transmit word give the length (8, 16 or 24). The data is left-aligned in bits 23:0. With bit 6 set, bit 23 goes out first; with bit 6 clear, the lowest bit of the field goes out first. A length of 0 or above 24 shifts 24 bits.
- R4: A read of address 0x20 returns the oldest receive entry in bits 23:0 and removes it, with data on bus_rdata one cycle after the read strobe. Address 0x0C returns the same entry without removing it. Control register 1 bit 1 set means the first received bit is the most significant bit of the field; clear means it is the least significant.
- R5: An entry written to 0x30 leaves cs_n low after it completes. An entry written to 0x20 drives cs_n high after it completes.
- R6: After every eighth bit, sclk rests at its idle level for one full serial clock period. A single 8-bit entry holds cs_n low for 18*(divider+1) cycles.
- R7: sclk rests at the level of control register 0 bit 7. Bit 8 selects whether mosi changes at the leading clock edge (1) or half a period earlier (0). Bit 10 selects whether miso is sampled at the trailing edge (1) or at the leading edge (0).
- R8: Status at 0x08 gives the TX level in 31:24, the RX level in 23:16, TX full in bit 10, TX empty in bit 9, RX full in bit 8, RX empty in bit 7, busy in bit 6, and the bit count in 5:0. Entries are returned in the order they were sent.
- R9: Each FIFO holds 4 entries. A transmit write while TX is full is dropped. A receive pop while RX is empty returns 0.
- R10: Writing control register 0 with bit 9 set empties both FIFOs and stops the engine, releasing cs_n.
- R11: irq is registered and is 1 when (control register 1 bit 6 and TX empty) or (control register 1 bit 7 and the engine is not busy). It is 0 otherwise.
- R12: The engine starts no entry while the RX FIFO is full. It resumes once an entry is popped.
- R13: With control register 0 bit 14 clear, every entry shifts the length in control register 0 bits 5:0, and bits 31:24 of the transmit word are ignored.
- R14: With control register 0 bit 11 clear, no entry is started and cs_n is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| miso | input | 1 | Serial data from the target |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the target |
| cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the clock polarity does not change while an idle gap is being timed. They also assume that bus_wr and bus_rd are single-cycle strobes that each name one address. The bench keeps to this by changing control register 0 only when the status shows the engine idle and the transmit queue empty. Every access is a one-cycle pulse driven on the falling clock edge. mosi is looped back to miso, so the received value is fully determined by the bit orders and the phase settings.

// File: rtl/vwspi_pkg.sv
package vwspi_pkg;
  localparam int unsigned DATA_W = 24;
  localparam int unsigned LEN_W  = 5;

  localparam logic [7:0] A_CTRL0     = 8'h00;
  localparam logic [7:0] A_CTRL1     = 8'h04;
  localparam logic [7:0] A_STAT      = 8'h08;
  localparam logic [7:0] A_PEEK      = 8'h0C;
  localparam logic [7:0] A_DATA_REL  = 8'h20;
  localparam logic [7:0] A_DATA_HOLD = 8'h30;

  localparam int unsigned C0_MSB_O  = 6;
  localparam int unsigned C0_CPOL   = 7;
  localparam int unsigned C0_CPHA_O = 8;
  localparam int unsigned C0_CLR    = 9;
  localparam int unsigned C0_CPHA_I = 10;
  localparam int unsigned C0_EN     = 11;
  localparam int unsigned C0_VAR    = 14;
  localparam int unsigned C0_DIV_LO = 20;
  localparam int unsigned C1_MSB_I  = 1;
  localparam int unsigned C1_IE_TXE = 6;
  localparam int unsigned C1_IE_IDL = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} eng_st_t;

  typedef struct packed {
    logic              hold;
    logic [LEN_W-1:0]  len;
    logic [DATA_W-1:0] data;
  } tx_ent_t;

  // Lengths outside 1..DATA_W fall back to the full width.
  function automatic logic [LEN_W-1:0] norm_len(input logic [7:0] raw);
    if (raw == 8'd0 || raw > 8'(DATA_W)) return LEN_W'(DATA_W);
    return raw[LEN_W-1:0];
  endfunction
endpackage

// File: rtl/vwspi_fifo.sv
module vwspi_fifo #(
  parameter int unsigned WIDTH = 24,
  parameter int unsigned DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clr,
  input  logic                           push,
  input  logic [WIDTH-1:0]               din,
  input  logic                           pop,
  output logic [WIDTH-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0]     level,
  output logic                           full,
  output logic                           empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             do_wr, do_rd;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign dout  = mem[rptr];
  assign level = cnt;

  // Storage without reset so the array can map onto RAM.
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      cnt <= cnt + CW'(do_wr) - CW'(do_rd);
    end
  end

  p_full_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> full);
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !clr) |=> empty);
  p_level_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/vwspi_engine.sv
module vwspi_engine
  import vwspi_pkg::*;
#(
  parameter int unsigned DIV_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              en,
  input  logic [DIV_W-1:0]  div,
  input  logic              cpol,
  input  logic              cpha_o,
  input  logic              cpha_i,
  input  logic              msb_o,
  input  logic              msb_i,
  input  logic              tx_avail,
  input  tx_ent_t           tx_ent,
  output logic              tx_pop,
  input  logic              rx_room,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              busy,
  output logic [LEN_W-1:0]  bitcnt
);
  eng_st_t           st;
  logic [DIV_W-1:0]  cnt;
  logic              half, hold_r, done_r;
  logic [LEN_W-1:0]  bitn, len_r, bits_nx;
  logic [DATA_W-1:0] sh, rsh, rsh_nx, sh_shift, load_sh;
  logic              tick, end_bit, last, byte_end, gap_end, fin, load, sample;

  assign tick     = (cnt == div);
  assign end_bit  = (st == ST_SHIFT) && tick && half;
  assign bits_nx  = bitn + LEN_W'(1);
  assign last     = end_bit && (bits_nx == len_r);
  assign byte_end = end_bit && (bits_nx[2:0] == 3'd0);
  assign gap_end  = (st == ST_GAP) && tick && half;
  assign fin      = (last && !byte_end) || (gap_end && done_r);
  assign load     = en && tx_avail && rx_room && ((st == ST_IDLE) || (fin && hold_r));
  assign sample   = (st == ST_SHIFT) && tick && (half ? cpha_i : !cpha_i);
  assign rsh_nx   = !sample ? rsh :
                    (msb_i ? {rsh[DATA_W-2:0], miso} : {miso, rsh[DATA_W-1:1]});
  assign sh_shift = msb_o ? (sh << 1) : (sh >> 1);
  assign load_sh  = msb_o ? tx_ent.data : (tx_ent.data >> (DATA_W - tx_ent.len));
  assign rx_data  = msb_i ? (rsh_nx << (DATA_W - len_r)) : rsh_nx;
  assign rx_push  = last;
  assign tx_pop   = load;
  assign busy     = (st != ST_IDLE);
  assign bitcnt   = bitn;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; half <= 1'b0; bitn <= '0; len_r <= LEN_W'(1);
      hold_r <= 1'b0; done_r <= 1'b0; sh <= '0; rsh <= '0;
      sclk <= 1'b0; mosi <= 1'b0; cs_n <= 1'b1;
    end else if (abort || !en) begin
      st <= ST_IDLE; cnt <= '0; half <= 1'b0; bitn <= '0;
      cs_n <= 1'b1; sclk <= cpol;
    end else if (load) begin
      st <= ST_SHIFT; cnt <= '0; half <= 1'b0; bitn <= '0;
      len_r <= tx_ent.len; hold_r <= tx_ent.hold; done_r <= 1'b0;
      sh <= load_sh; rsh <= '0; cs_n <= 1'b0; sclk <= cpol;
      if (!cpha_o) mosi <= msb_o ? load_sh[DATA_W-1] : load_sh[0];
    end else begin
      if (st == ST_IDLE) sclk <= cpol;
      else cnt <= tick ? '0 : cnt + DIV_W'(1);
      rsh <= rsh_nx;
      if (st == ST_SHIFT && tick) begin
        half <= ~half;
        if (!half) begin
          sclk <= ~cpol;
          if (cpha_o) mosi <= msb_o ? sh[DATA_W-1] : sh[0];
        end else begin
          sclk <= cpol;
          sh   <= sh_shift;
          bitn <= bits_nx;
          if (!cpha_o) mosi <= msb_o ? sh_shift[DATA_W-1] : sh_shift[0];
          if (byte_end) begin
            st     <= ST_GAP;
            done_r <= last;
          end
        end
      end
      if (st == ST_GAP && tick) begin
        half <= ~half;
        if (half && !done_r) st <= ST_SHIFT;
      end
      if (fin) begin
        st   <= ST_IDLE;
        bitn <= '0;
        cs_n <= !hold_r;
      end
    end
  end

  p_cs_active_r5: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> !cs_n);
  p_gap_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GAP) |-> (sclk == cpol));
  p_bit_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SHIFT) |-> (bitn < len_r));
  p_rx_no_overrun_r12: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> rx_room);
endmodule

// File: rtl/vwspi_master.sv
module vwspi_master
  import vwspi_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned DIV_W      = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  output logic        irq
);
  localparam int unsigned CW  = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned TXW = $bits(tx_ent_t);

  logic [31:0]       c0_q, c1_q, status;
  logic              wr_c0, clr, tx_push, rx_pop;
  tx_ent_t           tx_in, tx_head;
  logic [TXW-1:0]    tx_dout;
  logic [DATA_W-1:0] rx_head, rx_din;
  logic [CW-1:0]     tx_lvl, rx_lvl;
  logic              tx_full, tx_empty, rx_full, rx_empty, tx_pop, rx_push, busy;
  logic [LEN_W-1:0]  bitcnt;

  assign wr_c0   = bus_wr && (bus_addr == A_CTRL0);
  assign clr     = wr_c0 && bus_wdata[C0_CLR];
  assign tx_push = bus_wr && ((bus_addr == A_DATA_REL) || (bus_addr == A_DATA_HOLD));
  assign rx_pop  = bus_rd && (bus_addr == A_DATA_REL);

  assign tx_in.hold = (bus_addr == A_DATA_HOLD);
  assign tx_in.len  = norm_len(c0_q[C0_VAR] ? bus_wdata[31:24] : {2'b00, c0_q[5:0]});
  assign tx_in.data = bus_wdata[DATA_W-1:0];
  assign tx_head    = tx_ent_t'(tx_dout);

  assign status = {8'(tx_lvl), 8'(rx_lvl), 5'b0, tx_full, tx_empty,
                   rx_full, rx_empty, busy, 6'(bitcnt)};

  vwspi_fifo #(.WIDTH(TXW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(clr), .push(tx_push), .din(tx_in),
    .pop(tx_pop), .dout(tx_dout), .level(tx_lvl), .full(tx_full), .empty(tx_empty));

  vwspi_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(clr), .push(rx_push), .din(rx_din),
    .pop(rx_pop), .dout(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty));

  vwspi_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst(rst), .abort(clr), .en(c0_q[C0_EN]),
    .div(c0_q[C0_DIV_LO +: DIV_W]), .cpol(c0_q[C0_CPOL]),
    .cpha_o(c0_q[C0_CPHA_O]), .cpha_i(c0_q[C0_CPHA_I]),
    .msb_o(c0_q[C0_MSB_O]), .msb_i(c1_q[C1_MSB_I]),
    .tx_avail(!tx_empty), .tx_ent(tx_head), .tx_pop(tx_pop),
    .rx_room(!rx_full), .rx_push(rx_push), .rx_data(rx_din),
    .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .busy(busy), .bitcnt(bitcnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      c0_q <= '0;
      c1_q <= '0;
      bus_rdata <= '0;
      irq <= 1'b0;
    end else begin
      if (wr_c0) c0_q <= bus_wdata & ~(32'h1 << C0_CLR);
      if (bus_wr && bus_addr == A_CTRL1) c1_q <= bus_wdata;
      if (bus_rd) begin
        case (bus_addr)
          A_CTRL0:            bus_rdata <= c0_q;
          A_CTRL1:            bus_rdata <= c1_q;
          A_STAT:             bus_rdata <= status;
          A_PEEK, A_DATA_REL: bus_rdata <= rx_empty ? 32'h0 : {8'h00, rx_head};
          default:            bus_rdata <= 32'h0;
        endcase
      end
      irq <= (c1_q[C1_IE_TXE] && tx_empty) || (c1_q[C1_IE_IDL] && !busy);
    end
  end

  p_irq_off_r11: assert property (@(posedge clk) disable iff (rst)
    (!c1_q[C1_IE_TXE] && !c1_q[C1_IE_IDL]) |=> !irq);
  p_irq_txe_r11: assert property (@(posedge clk) disable iff (rst)
    (c1_q[C1_IE_TXE] && tx_empty) |=> irq);
  p_empty_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_DATA_REL && rx_empty) |=> (bus_rdata == 32'h0));
  p_disabled_idle_r14: assert property (@(posedge clk) disable iff (rst)
    !c0_q[C0_EN] |=> cs_n);
endmodule

// File: tb/sim_vwspi_master.sv
module sim_vwspi_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] AD_C0 = 8'h00, AD_C1 = 8'h04, AD_ST = 8'h08,
                         AD_PK = 8'h0C, AD_REL = 8'h20, AD_HOLD = 8'h30;
  // {div[3:0], cpol, cpha, msb_out, msb_in, len[7:0], data[23:0], expected[23:0]}
  localparam logic [63:0] VEC [6] = '{
    64'h1_3_08_A50000_A50000,
    64'h1_1_08_A10000_850000,
    64'h1_F_10_123400_123400,
    64'h0_4_18_ABCDEF_ABCDEF,
    64'h2_A_08_010000_800000,
    64'h2_3_18_5A3C96_5A3C96
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata, rd;
  logic miso, sclk, mosi, cs_n, irq;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  assign miso = mosi;
  always #(CLK_PERIOD / 2) clk = ~clk;

  vwspi_master u0 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rdreg(AD_ST, s);
      if (!s[6] && s[31:24] == 8'd0) break;
    end
  endtask

  function automatic logic [31:0] c0v(input int dv, input bit en, input bit vw,
      input bit cpol, input bit cpha, input bit mo, input int len);
    return (32'(dv) << 20) | (32'(en) << 11) | (32'(vw) << 14) | (32'(cpha) << 8) |
           (32'(cpha) << 10) | (32'(cpol) << 7) | (32'(mo) << 6) | 32'(len);
  endfunction

  task automatic measure(output int lo, output int hi);
    bit seen = 1'b0;
    lo = 0; hi = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!cs_n) begin seen = 1'b1; lo++; if (sclk) hi++; end
      else if (seen) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int lo, hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 cs_n", 32'(cs_n), 32'd1);
    check("R1 sclk", 32'(sclk), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    rdreg(AD_ST, rd); check("R1 status", rd, 32'h0000_0280);

    // Table: loopback through every order and phase mode (R3 R4 R7)
    for (int v = 0; v < 6; v++) begin
      wr(AD_C1, 32'(VEC[v][56]) << 1);
      wr(AD_C0, c0v(int'(VEC[v][63:60]), 1, 1, VEC[v][59], VEC[v][58], VEC[v][57], 0));
      wr(AD_REL, {VEC[v][55:48], VEC[v][47:24]});
      wait_idle();
      rdreg(AD_REL, rd);
      check($sformatf("R3 R4 R7 vector %0d", v), rd, {8'h00, VEC[v][23:0]});
    end

    // R2 R6: timing of one 8-bit entry at divider 4 and one 16-bit entry at divider 1
    wr(AD_C1, 32'h2);
    wr(AD_C0, c0v(4, 1, 1, 0, 0, 1, 0));
    wr(AD_REL, 32'h08_5A0000);
    measure(lo, hi);
    check("R6 cs low cycles 8b div4", 32'(lo), 32'd90);
    check("R2 sclk high cycles div4", 32'(hi), 32'd40);
    rdreg(AD_REL, rd);
    wr(AD_C0, c0v(1, 1, 1, 0, 0, 1, 0));
    wr(AD_REL, 32'h10_F00F00);
    measure(lo, hi);
    check("R6 cs low cycles 16b div1", 32'(lo), 32'd72);
    check("R2 sclk high cycles div1", 32'(hi), 32'd32);
    rdreg(AD_REL, rd);
    check("R4 16b data", rd, 32'h00F00F00);

    // R5: hold then release
    wr(AD_HOLD, 32'h08_3C0000);
    wait_idle();
    check("R5 cs held after hold entry", 32'(cs_n), 32'd0);
    wr(AD_REL, 32'h08_C30000);
    wait_idle();
    check("R5 cs released after release entry", 32'(cs_n), 32'd1);

    // R4: peek does not pop
    rdreg(AD_PK, rd); check("R4 peek first", rd, 32'h003C0000);
    rdreg(AD_PK, rd); check("R4 peek again", rd, 32'h003C0000);
    rdreg(AD_ST, rd); check("R4 level after peek", 32'(rd[23:16]), 32'd2);
    rdreg(AD_REL, rd); check("R4 pop first", rd, 32'h003C0000);
    rdreg(AD_REL, rd); check("R4 pop second", rd, 32'h00C30000);

    // R13: fixed length, top byte ignored
    wr(AD_C0, c0v(1, 1, 0, 0, 0, 1, 8));
    wr(AD_REL, 32'hFF_C30000);
    wait_idle();
    rdreg(AD_REL, rd); check("R13 fixed length 8", rd, 32'h00C30000);
    rdreg(AD_ST, rd); check("R13 only one entry", 32'(rd[23:16]), 32'd0);

    // R8 R12: fill RX, then stall
    wr(AD_C0, c0v(0, 1, 1, 0, 0, 1, 0));
    for (int k = 1; k <= 4; k++) wr(AD_REL, {8'h08, 8'(k * 17), 16'h0});
    wait_idle();
    rdreg(AD_ST, rd); check("R8 status rx full", rd, 32'h0004_0300);
    wr(AD_REL, 32'h08_550000);
    repeat (60) @(negedge clk);
    check("R12 no start while rx full", 32'(cs_n), 32'd1);
    rdreg(AD_ST, rd); check("R12 tx entry waits", 32'(rd[31:24]), 32'd1);
    rdreg(AD_REL, rd); check("R8 order first", rd, 32'h00110000);
    wait_idle();
    rdreg(AD_ST, rd); check("R12 resumes after pop", 32'(rd[23:16]), 32'd4);
    for (int k = 2; k <= 5; k++) begin
      rdreg(AD_REL, rd); check("R8 order", rd, {8'h00, 8'(k * 17), 16'h0});
    end

    // R14 R9 R10: disabled engine, overfill, empty pop, clear
    wr(AD_C0, c0v(0, 0, 1, 0, 0, 1, 0));
    for (int k = 0; k < 5; k++) wr(AD_REL, 32'h08_AA0000);
    repeat (20) @(negedge clk);
    check("R14 disabled keeps cs high", 32'(cs_n), 32'd1);
    rdreg(AD_ST, rd); check("R9 tx full, fifth dropped", rd, 32'h0400_0480);
    rdreg(AD_REL, rd); check("R9 empty pop returns zero", rd, 32'h0);
    wr(AD_C0, 32'h0000_0200);
    rdreg(AD_ST, rd); check("R10 clear empties", rd, 32'h0000_0280);

    // R11: interrupt sources
    wr(AD_C1, 32'h80); @(negedge clk);
    check("R11 idle irq", 32'(irq), 32'd1);
    wr(AD_C1, 32'h0); @(negedge clk);
    check("R11 irq off", 32'(irq), 32'd0);
    wr(AD_C0, c0v(7, 1, 1, 0, 0, 1, 0));
    wr(AD_C1, 32'h82);
    wr(AD_REL, 32'h08_770000);
    repeat (20) @(negedge clk);
    check("R11 busy masks idle irq", 32'(irq), 32'd0);
    wr(AD_C1, 32'h42); @(negedge clk);
    check("R11 tx empty irq", 32'(irq), 32'd1);
    wr(AD_C1, 32'h2);
    wait_idle();
    rdreg(AD_REL, rd); check("R4 slow entry data", rd, 32'h00770000);

    // R7: idle clock level follows polarity
    wr(AD_C0, c0v(1, 1, 1, 1, 0, 1, 0)); @(negedge clk);
    check("R7 idle high", 32'(sclk), 32'd1);
    wr(AD_C0, c0v(1, 1, 1, 0, 0, 1, 0)); @(negedge clk);
    check("R7 idle low", 32'(sclk), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule